// File: doc/BRIEF.md
# Partitioned SIMD Packed Adder

One 32-bit adder whose carry chain is cut at byte boundaries under control of a mode input. The same hardware therefore acts as one 32-bit adder, two independent 16-bit adders, or four independent 8-bit adders. Every lane performs the same addition in the same cycle on its own slice of the two operand words.

Packed data always travels as one 32-bit word. Lane 0 holds the lowest bits, and each higher lane takes the next higher bits in order.

A request is accepted on any cycle where the valid input is high. One clock later the packed sum, a per-lane carry-out vector and a matching valid output appear on registered outputs.

Top module: `psa_packed_adder`

## Requirements
- R1: With mode 2'b00 the sum output equals (a + b) mod 2^32, and carry bit 3 equals the carry out of bit 31.
- R2: With mode 2'b01 the word splits into two lanes: lane 0 is bits [15:0] and lane 1 is bits [31:16]. Each lane sum is (a_lane + b_lane) mod 2^16. Carry bit 1 holds the carry of lane 0 and carry bit 3 holds the carry of lane 1.
- R3: With mode 2'b10 the word splits into four 8-bit lanes, and lane k is bits [8k+7:8k]. Each lane sum is (a_lane + b_lane) mod 256, and carry bit k holds the carry out of lane k.
- R4: Mode 2'b11 behaves exactly like mode 2'b10.
- R5: No carry crosses a lane boundary. In 8-bit mode no carry enters bit 8, 16 or 24. In 16-bit mode no carry enters bit 16.
- R6: Carry bits that do not belong to a lane read zero. In 32-bit mode these are bits 2:0. In 16-bit mode these are bits 0 and 2.
- R7: A request accepted while in_valid is high produces its result, with out_valid high, on the next clock. out_valid is low on the clock after a cycle where in_valid is low.
- R8: A synchronous active-high reset clears out_valid, the sum and the carry vector to zero.
- R9: While in_valid is low, the sum and carry outputs keep their previous values whatever the operand and mode inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Accept operands and mode this cycle |
| a_i | input | 32 | Packed operand A |
| b_i | input | 32 | Packed operand B |
| mode_i | input | 2 | Lane mode: 00 = 32-bit, 01 = 16-bit, 10 and 11 = 8-bit |
| out_valid_o | output | 1 | Result valid, one clock after the request |
| sum_o | output | 32 | Packed lane sums |
| carry_o | output | 4 | Carry out, reported at the top byte of each lane |

## Verification
Each mode is swept over a grid of byte values. The four bytes of each operand are different functions of the sweep index, so a lane that picks up a neighbour's data or carry gives a wrong result.

All-ones words added to a one in every lane make the carry ripple to each boundary. This separates a correctly cut chain from one that leaks across a boundary, and it also shows which carry bits each mode must leave at zero.

Pseudo-random words cover the remaining mixes. Extra sequences change the operands while in_valid is low, and assert reset, to show the hold, latency and clear behaviour.

// File: rtl/psa_pkg.sv
package psa_pkg;

  typedef enum logic [1:0] {
    MODE_W32  = 2'b00,
    MODE_W16  = 2'b01,
    MODE_W8   = 2'b10,
    MODE_W8B  = 2'b11
  } psa_mode_e;

  // Partition depth: 0 = one lane, 1 = halves, 2 = quarters.
  function automatic int mode_level(input logic [1:0] m);
    case (m)
      2'b00:   return 0;
      2'b01:   return 1;
      default: return 2;
    endcase
  endfunction

  // Number of byte slices that form one lane.
  function automatic int group_size(input int slices, input logic [1:0] m);
    int g;
    g = slices >> mode_level(m);
    if (g < 1) g = 1;
    return g;
  endfunction

  // Number of lanes in the word for a mode.
  function automatic int lane_count(input int slices, input logic [1:0] m);
    return slices / group_size(slices, m);
  endfunction

endpackage

// File: rtl/psa_lane_ctrl.sv
module psa_lane_ctrl #(
  parameter int SLICES = 4
) (
  input  logic [1:0]        mode_i,
  output logic [SLICES-1:0] link_en_o,
  output logic [SLICES-1:0] lane_end_o
);
  int gsize;

  always_comb begin
    gsize = psa_pkg::group_size(SLICES, mode_i);
    for (int i = 0; i < SLICES; i++) begin
      link_en_o[i]  = (i % gsize) != 0;
      lane_end_o[i] = ((i + 1) % gsize) == 0;
    end
  end

  // R5: in the byte modes no slice may take a carry from its neighbour.
  always_comb begin
    if (!$isunknown(mode_i)) begin
      p_byte_cut_r5: assert (!mode_i[1] || link_en_o == '0)
        else $error("byte mode left a carry link open");
      p_top_end_r6: assert (lane_end_o[SLICES-1])
        else $error("top slice is not a lane end");
    end
  end

  // R5/R6: a carry link into slice i exists exactly when slice i-1 does not end a lane.
  for (genvar i = 1; i < SLICES; i++) begin : g_chk
    always_comb begin
      if (!$isunknown(mode_i)) begin
        p_link_vs_end_r5: assert (link_en_o[i] == !lane_end_o[i-1])
          else $error("link and lane end disagree at slice %0d", i);
      end
    end
  end
endmodule

// File: rtl/psa_slice.sv
module psa_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] full;

  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/psa_packed_adder.sv
module psa_packed_adder #(
  parameter int SLICE_W = 8,
  parameter int SLICES  = 4,
  localparam int DATA_W = SLICE_W * SLICES
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        mode_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] sum_o,
  output logic [SLICES-1:0] carry_o
);
  logic [SLICES-1:0] link_en;
  logic [SLICES-1:0] lane_end;
  logic [SLICES-1:0] slice_cin;
  logic [SLICES-1:0] slice_cout;
  logic [DATA_W-1:0] sum_next;
  logic [SLICES-1:0] carry_next;
  logic [1:0]        mode_q;

  psa_lane_ctrl #(.SLICES(SLICES)) u_ctrl (
    .mode_i    (mode_i),
    .link_en_o (link_en),
    .lane_end_o(lane_end)
  );

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    if (i == 0) begin : g_first
      assign slice_cin[i] = 1'b0;
    end else begin : g_rest
      assign slice_cin[i] = slice_cout[i-1] & link_en[i];
    end

    psa_slice #(.W(SLICE_W)) u_slice (
      .a_i   (a_i[i*SLICE_W +: SLICE_W]),
      .b_i   (b_i[i*SLICE_W +: SLICE_W]),
      .cin_i (slice_cin[i]),
      .sum_o (sum_next[i*SLICE_W +: SLICE_W]),
      .cout_o(slice_cout[i])
    );

    assign carry_next[i] = slice_cout[i] & lane_end[i];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      out_valid_o <= 1'b0;
      sum_o       <= '0;
      carry_o     <= '0;
      mode_q      <= 2'b00;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        sum_o   <= sum_next;
        carry_o <= carry_next;
        mode_q  <= mode_i;
      end
    end
  end

  // R7: a result appears exactly one clock after an accepted request.
  p_valid_lat_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    in_valid_i |=> out_valid_o)
    else $error("missing out_valid after request");
  p_idle_lat_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !in_valid_i |=> !out_valid_o)
    else $error("out_valid without request");

  // R9: the outputs hold while no request is accepted.
  p_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !in_valid_i |=> ($stable(sum_o) && $stable(carry_o)))
    else $error("outputs moved without request");

  // R6: no more carry flags than the registered mode has lanes.
  p_carry_count_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    out_valid_o |-> ($countones(carry_o) <= psa_pkg::lane_count(SLICES, mode_q)))
    else $error("more carry flags than lanes");
  p_w32_unused_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_valid_o && mode_q == 2'b00) |-> (carry_o[SLICES-2:0] == '0))
    else $error("low carry bits set in 32-bit mode");
endmodule

// File: tb/sim_psa_packed_adder.sv
module sim_psa_packed_adder;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] a, b;
  logic [1:0]  mode;
  logic        out_valid;
  logic [31:0] sum;
  logic [3:0]  carry;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  psa_packed_adder u0 (
    .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid),
    .a_i(a), .b_i(b), .mode_i(mode),
    .out_valid_o(out_valid), .sum_o(sum), .carry_o(carry)
  );

  function automatic void model(input logic [31:0] x, input logic [31:0] y,
                                input logic [1:0] m,
                                output logic [31:0] s, output logic [3:0] c);
    int w;
    logic [32:0] t;
    logic [32:0] msk;
    w = (m == 2'b00) ? 32 : (m == 2'b01) ? 16 : 8;
    msk = (33'd1 << w) - 33'd1;
    s = '0;
    c = '0;
    for (int k = 0; k < 32 / w; k++) begin
      t = ((33'(x) >> (k * w)) & msk) + ((33'(y) >> (k * w)) & msk);
      s = s | 32'((t & msk) << (k * w));
      c[(k + 1) * (w / 8) - 1] = t[w];
    end
  endfunction

  function automatic string tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] x, input logic [31:0] y,
                        input logic [1:0] m, input string req);
    logic [31:0] es;
    logic [3:0]  ec;
    @(negedge clk);
    a = x; b = y; mode = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(x, y, m, es, ec);
    check(req, {27'd0, out_valid, carry, sum}, {27'd0, 1'b1, ec, es});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    logic [31:0] hs;
    logic [3:0]  hc;
    rst = 1'b1; in_valid = 1'b0; a = '0; b = '0; mode = 2'b00;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", {27'd0, out_valid, carry, sum}, 64'd0);
    rst = 1'b0;

    // R1..R4: byte-grid sweep per mode, distinct data in every byte
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 256; i += 5) begin
        for (int j = 0; j < 256; j += 7) begin
          logic [7:0] x, y;
          x = 8'(i); y = 8'(j);
          run_op({x, x ^ 8'h5A, ~x, x + 8'd3}, {y + 8'd1, y, y ^ 8'hC3, ~y},
                 2'(m), tag(2'(m)));
        end
      end
    end

    // R5: carry ripple to every boundary
    run_op(32'hFFFF_FFFF, 32'h0101_0101, 2'b10, "R5");
    check("R5", {28'd0, carry, sum}, {28'd0, 4'b1111, 32'h0000_0000});
    run_op(32'hFFFF_FFFF, 32'h0001_0001, 2'b01, "R5");
    check("R5", {28'd0, carry, sum}, {28'd0, 4'b1010, 32'h0000_0000});
    run_op(32'h00FF_00FF, 32'h0001_0001, 2'b10, "R5");
    check("R5", {28'd0, carry, sum}, {28'd0, 4'b0101, 32'h0000_0000});
    run_op(32'hFFFF_FFFF, 32'h0000_0001, 2'b00, "R1");
    check("R1", {28'd0, carry, sum}, {28'd0, 4'b1000, 32'h0000_0000});

    // R6: unused carry bits stay zero even when inner carries occur
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, "R6");
    check("R6", {60'd0, carry & 4'b0111}, 64'd0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b01, "R6");
    check("R6", {60'd0, carry & 4'b0101}, 64'd0);
    run_op(32'hFF00_FF00, 32'h8000_8000, 2'b11, "R4");

    // pseudo-random mixes
    lf = 32'h1234_5678;
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] x;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      x = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run_op(x, lf ^ 32'h9E37_79B9, 2'(n % 4), tag(2'(n % 4)));
    end

    // R9 and R7: idle cycles leave outputs alone, out_valid drops
    run_op(32'h1111_1111, 32'h2222_2222, 2'b00, "R7");
    model(32'h1111_1111, 32'h2222_2222, 2'b00, hs, hc);
    @(negedge clk);
    a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; mode = 2'b10; in_valid = 1'b0;
    @(negedge clk);
    check("R7", {63'd0, out_valid}, 64'd0);
    check("R9", {28'd0, carry, sum}, {28'd0, hc, hs});
    @(negedge clk);
    check("R9", {28'd0, carry, sum}, {28'd0, hc, hs});

    // R8: reset after activity
    @(negedge clk);
    a = 32'h8000_0000; b = 32'h8000_0000; mode = 2'b00; in_valid = 1'b1;
    @(negedge clk);
    check("R7", {28'd0, carry, sum}, {28'd0, 4'b1000, 32'h0});
    rst = 1'b1;
    @(negedge clk);
    check("R8", {27'd0, out_valid, carry, sum}, 64'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule